// File: doc/BRIEF.md
# 52-bit Integer Multiply-Accumulate Vector Unit

This unit runs a packed multiply-accumulate over up to eight 64-bit lanes. Every lane keeps only the low 52 bits of its two multiplicands and forms their 104-bit product. It then adds one 52-bit half of that product to the lane's 64-bit accumulator. A mode input picks the half: low mode takes product bits 51:0 and high mode takes bits 103:52. The sum wraps modulo 2^64.

A vector-length select sets how many lanes are active: two, four or eight. An optional per-lane mask controls which active lanes take the new sum. A lane whose mask bit is clear keeps its old accumulator value, or is cleared to zero when zeroing is requested. Lanes above the vector length always read as zero.

The multiplier is iterative. It consumes a fixed-width digit of the second operand on each cycle. For that reason the unit uses a start/done handshake. A start pulse captures every operand and control input. When the results are written, done pulses for one cycle. The result vector then stays unchanged until the next operation completes.

Top module: `mac52_vec_unit`

## Requirements
- R1: Bits 63:52 of each source lane are ignored, so only bits 51:0 enter the multiply.
- R2: When hi_sel is 0, a lane adds product bits 51:0, zero-extended to 64 bits, to its accumulator lane.
- R3: When hi_sel is 1, a lane adds product bits 103:52, zero-extended to 64 bits, to its accumulator lane.
- R4: The accumulation wraps modulo 2^64, with no saturation and no carry reported.
- R5: vlen_sel encodes the active lane count: 0 gives 2 lanes, 1 gives 4 lanes, and 2 or 3 give 8 lanes. Lanes at or above that count output zero.
- R6: When mask_en is 1 and zero_en is 0, an active lane n with lane_mask bit n clear outputs its acc_in value unchanged.
- R7: When mask_en is 1 and zero_en is 1, an active lane n with lane_mask bit n clear outputs zero.
- R8: When mask_en is 0, every active lane outputs its new sum, whatever lane_mask holds.
- R9: All inputs are captured on the rising edge where start is 1 and busy is 0. Later input changes have no effect on that result, and busy is 1 in the following cycle.
- R10: done is 1 for exactly one cycle. It rises on the fifth rising edge after the accepting edge (digit count plus one, with the default 13-bit digit). A start that arrives while busy is 1 is ignored.
- R11: After reset, acc_out is zero and done is 0. acc_out changes only on the edge that raises done, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; captures all inputs when the unit is idle |
| src_a | input | 512 | First multiplicand vector, 64 bits per lane |
| src_b | input | 512 | Second multiplicand vector, 64 bits per lane |
| acc_in | input | 512 | Accumulator vector, 64 bits per lane |
| vlen_sel | input | 2 | Active lane count select (see R5) |
| hi_sel | input | 1 | 0 adds the low product half, 1 adds the high half |
| mask_en | input | 1 | Enables per-lane masking |
| lane_mask | input | 8 | Bit n controls lane n |
| zero_en | input | 1 | Masked-off lanes are cleared instead of kept |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when acc_out is updated |
| acc_out | output | 512 | Updated accumulator vector |

## Verification
A corrupted partial product or a wrong digit shift shows only in the result vector, on the done edge. The bench compares every lane against a full 104-bit reference, using all-ones multiplicands and overflowing accumulators, so that bit errors in either product half become visible. A stuck sequencer shows up in the ports as a wrong done latency, a repeated done pulse or a missing one. Operand capture faults appear when inputs are disturbed right after start. Merge faults appear as lanes that differ at the mask or vector-length boundaries.

// File: rtl/mac52_pkg.sv
package mac52_pkg;

    localparam int LANE_W  = 64;
    localparam int MUL_W   = 52;
    localparam int PROD_W  = 2 * MUL_W;
    localparam int MASK_W  = 8;
    localparam int PAD_W   = LANE_W - MUL_W;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              hi;
        logic              mask_en;
        logic              zero_en;
        logic [MASK_W-1:0] mask;
        logic [1:0]        vlen;
    } op_cfg_t;

    function automatic int unsigned lanes_for(input logic [1:0] vsel);
        case (vsel)
            2'd0:    return 2;
            2'd1:    return 4;
            default: return 8;
        endcase
    endfunction

    function automatic logic [LANE_W-1:0] fold_sum(
        input logic [LANE_W-1:0] acc,
        input logic [PROD_W-1:0] prod,
        input logic              hi
    );
        logic [MUL_W-1:0] half;
        half = hi ? prod[PROD_W-1:MUL_W] : prod[MUL_W-1:0];
        return acc + {{PAD_W{1'b0}}, half};
    endfunction

endpackage

// File: rtl/mac52_seq.sv
module mac52_seq
    import mac52_pkg::*;
#(
    parameter int ITERS  = 4,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              load,
    output logic              step,
    output logic [STEP_W-1:0] step_idx,
    output logic              finish,
    output logic              busy
);

    seq_state_e        state;
    logic [STEP_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_RUN;
                        idx   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (idx == STEP_W'(ITERS - 1)) begin
                        state <= SEQ_FIN;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SEQ_FIN:  state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    assign load     = (state == SEQ_IDLE) && start;
    assign step     = (state == SEQ_RUN);
    assign finish   = (state == SEQ_FIN);
    assign busy     = (state != SEQ_IDLE);
    assign step_idx = idx;

endmodule

// File: rtl/mac52_lane.sv
module mac52_lane
    import mac52_pkg::*;
#(
    parameter int DIGIT_W = 13,
    parameter int STEP_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [STEP_W-1:0] step_idx,
    input  logic [LANE_W-1:0] a_in,
    input  logic [LANE_W-1:0] b_in,
    input  logic [LANE_W-1:0] acc_in,
    output logic [PROD_W-1:0] prod,
    output logic [LANE_W-1:0] acc_old
);

    localparam int PART_W = MUL_W + DIGIT_W;
    localparam int SH_W   = $clog2(PROD_W) + 1;

    logic [MUL_W-1:0]  a_q;
    logic [MUL_W-1:0]  b_q;
    logic [LANE_W-1:0] acc_q;
    logic [PROD_W-1:0] prod_q;
    logic [PART_W-1:0] partial;
    logic [SH_W-1:0]   shamt;
    logic [PROD_W-1:0] ext;
    logic              unused_hi_bits;

    // upper source bits never reach the multiplier
    assign unused_hi_bits = ^{a_in[LANE_W-1:MUL_W], b_in[LANE_W-1:MUL_W]};

    assign partial = PART_W'(a_q) * PART_W'(b_q[DIGIT_W-1:0]);
    assign shamt   = SH_W'(step_idx) * SH_W'(DIGIT_W);
    assign ext     = PROD_W'(partial) << shamt;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            acc_q  <= '0;
            prod_q <= '0;
        end else if (load) begin
            a_q    <= a_in[MUL_W-1:0];
            b_q    <= b_in[MUL_W-1:0];
            acc_q  <= acc_in;
            prod_q <= '0;
        end else if (step) begin
            prod_q <= prod_q + ext;
            b_q    <= b_q >> DIGIT_W;
        end
    end

    assign prod    = prod_q;
    assign acc_old = acc_q;

endmodule

// File: rtl/mac52_merge.sv
module mac52_merge
    import mac52_pkg::*;
#(
    parameter int IDX = 0
) (
    input  op_cfg_t           cfg,
    input  logic [PROD_W-1:0] prod,
    input  logic [LANE_W-1:0] acc_old,
    output logic [LANE_W-1:0] res
);

    logic              active;
    logic              keep_old;
    logic [LANE_W-1:0] sum;

    assign active   = (IDX < lanes_for(cfg.vlen));
    assign keep_old = cfg.mask_en && !cfg.mask[IDX];
    assign sum      = fold_sum(acc_old, prod, cfg.hi);

    always_comb begin
        if (!active) begin
            res = '0;
        end else if (keep_old) begin
            res = cfg.zero_en ? '0 : acc_old;
        end else begin
            res = sum;
        end
    end

endmodule

// File: rtl/mac52_vec_unit.sv
module mac52_vec_unit
    import mac52_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int DIGIT_W = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic [LANES*LANE_W-1:0] acc_in,
    input  logic [1:0]              vlen_sel,
    input  logic                    hi_sel,
    input  logic                    mask_en,
    input  logic [MASK_W-1:0]       lane_mask,
    input  logic                    zero_en,
    output logic                    busy,
    output logic                    done,
    output logic [LANES*LANE_W-1:0] acc_out
);

    localparam int ITERS  = (MUL_W + DIGIT_W - 1) / DIGIT_W;
    localparam int STEP_W = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam int VEC_W  = LANES * LANE_W;

    logic              load;
    logic              step;
    logic              finish;
    logic [STEP_W-1:0] step_idx;
    op_cfg_t           cfg_q;
    logic [1:0]        cfg_vlen;
    logic [VEC_W-1:0]  merged;

    mac52_seq #(
        .ITERS  (ITERS),
        .STEP_W (STEP_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load     (load),
        .step     (step),
        .step_idx (step_idx),
        .finish   (finish),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q.hi      <= hi_sel;
            cfg_q.mask_en <= mask_en;
            cfg_q.zero_en <= zero_en;
            cfg_q.mask    <= lane_mask;
            cfg_q.vlen    <= vlen_sel;
        end
    end

    assign cfg_vlen = cfg_q.vlen;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PROD_W-1:0] prod;
        logic [LANE_W-1:0] acc_old;

        mac52_lane #(
            .DIGIT_W (DIGIT_W),
            .STEP_W  (STEP_W)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .step     (step),
            .step_idx (step_idx),
            .a_in     (src_a[g*LANE_W +: LANE_W]),
            .b_in     (src_b[g*LANE_W +: LANE_W]),
            .acc_in   (acc_in[g*LANE_W +: LANE_W]),
            .prod     (prod),
            .acc_old  (acc_old)
        );

        mac52_merge #(
            .IDX (g)
        ) u_merge (
            .cfg     (cfg_q),
            .prod    (prod),
            .acc_old (acc_old),
            .res     (merged[g*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out <= '0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                acc_out <= merged;
            end
        end
    end

endmodule

// File: rtl/mac52_vec_unit_chk.sv
module mac52_vec_unit_chk
    import mac52_pkg::*;
#(
    parameter int LANES = 8,
    parameter int ITERS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic [1:0]              vlen_q,
    input logic [LANES*LANE_W-1:0] acc_out
);

    logic [7:0]              lat_cnt;
    logic [LANES*LANE_W-1:0] upper;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
        end else if (start && !busy) begin
            lat_cnt <= 8'd1;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 8'd1;
        end
    end

    always_comb begin
        upper = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i >= int'(lanes_for(vlen_q))) begin
                upper[i*LANE_W +: LANE_W] = '1;
            end
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_latency_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == 8'(ITERS + 2)));

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(acc_out));

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> ((acc_out & upper) == '0));

endmodule

bind mac52_vec_unit mac52_vec_unit_chk #(
    .LANES (LANES),
    .ITERS (ITERS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .vlen_q  (cfg_vlen),
    .acc_out (acc_out)
);

// File: tb/mac52_vec_unit_test.sv
module mac52_vec_unit_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [511:0] src_a;
    logic [511:0] src_b;
    logic [511:0] acc_in;
    logic [1:0]   vlen_sel;
    logic         hi_sel;
    logic         mask_en;
    logic [7:0]   lane_mask;
    logic         zero_en;
    logic         busy;
    logic         done;
    logic [511:0] acc_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam int EXP_WAIT = 6;  // negedges from the accepting edge to done

    always #2.5 clk = ~clk;

    mac52_vec_unit uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .src_a     (src_a),
        .src_b     (src_b),
        .acc_in    (acc_in),
        .vlen_sel  (vlen_sel),
        .hi_sel    (hi_sel),
        .mask_en   (mask_en),
        .lane_mask (lane_mask),
        .zero_en   (zero_en),
        .busy      (busy),
        .done      (done),
        .acc_out   (acc_out)
    );

    task automatic check_vec(input string req, input string what,
                             input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_lane(input logic [63:0] a, input logic [63:0] b,
                                             input logic [63:0] acc, input logic hi);
        logic [103:0] p;
        p = {52'd0, a[51:0]} * {52'd0, b[51:0]};
        return hi ? acc + {12'd0, p[103:52]} : acc + {12'd0, p[51:0]};
    endfunction

    function automatic logic [511:0] ref_vec(input logic [511:0] a, input logic [511:0] b,
                                             input logic [511:0] acc, input logic [1:0] vs,
                                             input logic hi, input logic men,
                                             input logic [7:0] mk, input logic zen);
        logic [511:0] r;
        int cnt;
        cnt = (vs == 2'd0) ? 2 : (vs == 2'd1) ? 4 : 8;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            if (i >= cnt)
                r[i*64 +: 64] = '0;
            else if (men && !mk[i])
                r[i*64 +: 64] = zen ? 64'd0 : acc[i*64 +: 64];
            else
                r[i*64 +: 64] = ref_lane(a[i*64 +: 64], b[i*64 +: 64], acc[i*64 +: 64], hi);
        end
        return r;
    endfunction

    // one operation; disturb changes every input after capture and pokes start while busy
    task automatic run_op(input string req, input logic [511:0] a, input logic [511:0] b,
                          input logic [511:0] acc, input logic [1:0] vs, input logic hi,
                          input logic men, input logic [7:0] mk, input logic zen,
                          input bit disturb);
        logic [511:0] exp;
        logic [511:0] held;
        int n;
        exp = ref_vec(a, b, acc, vs, hi, men, mk, zen);
        @(negedge clk);
        src_a = a; src_b = b; acc_in = acc; vlen_sel = vs; hi_sel = hi;
        mask_en = men; lane_mask = mk; zero_en = zen; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        if (disturb) begin
            src_a = ~a; src_b = a ^ b; acc_in = ~acc; vlen_sel = ~vs;
            hi_sel = ~hi; mask_en = ~men; lane_mask = ~mk; zero_en = ~zen;
        end
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            start = (disturb && n == 2);
        end
        start = 1'b0;
        check_int("R10", {req, " done latency"}, n, EXP_WAIT);
        check_vec(req, "lane results", acc_out, exp);
        held = acc_out;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done || acc_out !== held) begin
                check_int("R11", "hold after done (done, changed)", int'(done) + 2 * int'(acc_out !== held), 0);
                k = 8;
            end
        end
        checks++;
    endtask

    task automatic t_reset;
        check_vec("R11", "acc_out after reset", acc_out, '0);
        check_int("R11", "done after reset", int'(done), 0);
        check_int("R11", "busy after reset", int'(busy), 0);
    endtask

    task automatic t_low_mode;
        logic [511:0] a, b, acc;
        for (int i = 0; i < 8; i++) begin
            a[i*64 +: 64]   = 64'h0000_1234_5678_9ABC + 64'(i * 977);
            b[i*64 +: 64]   = 64'h0000_0FED_CBA9_8765 - 64'(i * 31);
            acc[i*64 +: 64] = 64'(i) << 40;
        end
        // R2 low half; R8 mask bits zero but masking disabled
        run_op("R2", a, b, acc, 2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 0);
        run_op("R8", a, b, acc, 2'd2, 1'b0, 1'b0, 8'h00, 1'b1, 0);
    endtask

    task automatic t_high_corner;
        logic [511:0] a, b, acc;
        for (int i = 0; i < 8; i++) begin
            a[i*64 +: 64]   = (i % 2 == 0) ? 64'h000F_FFFF_FFFF_FFFF : 64'h0008_0000_0000_0001;
            b[i*64 +: 64]   = (i < 4) ? 64'h000F_FFFF_FFFF_FFFF : 64'h000A_5A5A_5A5A_5A5A;
            acc[i*64 +: 64] = 64'd7 * 64'(i);
        end
        run_op("R3", a, b, acc, 2'd3, 1'b1, 1'b0, 8'hFF, 1'b0, 0);
        run_op("R2", a, b, acc, 2'd3, 1'b0, 1'b0, 8'hFF, 1'b0, 0);
    endtask

    task automatic t_upper_bits;
        logic [511:0] a, b, acc;
        for (int i = 0; i < 8; i++) begin
            a[i*64 +: 64]   = {12'hABC, 52'h1_2345_6789_ABCD} ^ 64'(i);
            b[i*64 +: 64]   = {12'hFFF, 52'h9_8765_4321_0FED};
            acc[i*64 +: 64] = 64'h1111_2222_3333_4444;
        end
        run_op("R1", a, b, acc, 2'd2, 1'b1, 1'b0, 8'h00, 1'b0, 0);
        run_op("R1", a, b, acc, 2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 0);
    endtask

    task automatic t_wrap;
        logic [511:0] a, b, acc;
        for (int i = 0; i < 8; i++) begin
            a[i*64 +: 64]   = 64'h000F_FFFF_FFFF_FFFF;
            b[i*64 +: 64]   = 64'h000F_FFFF_FFFF_FFF0 + 64'(i);
            acc[i*64 +: 64] = 64'hFFFF_FFFF_FFFF_FFFF - 64'(i);
        end
        run_op("R4", a, b, acc, 2'd2, 1'b1, 1'b0, 8'h00, 1'b0, 0);
        run_op("R4", a, b, acc, 2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 0);
    endtask

    task automatic t_vlen;
        logic [511:0] a, b, acc;
        for (int i = 0; i < 8; i++) begin
            a[i*64 +: 64]   = 64'h0003_0000_0000_0005 * 64'(i + 1);
            b[i*64 +: 64]   = 64'h0000_7777_0000_0003;
            acc[i*64 +: 64] = 64'hDEAD_0000_0000_0000 | 64'(i);
        end
        for (int v = 0; v < 4; v++) begin
            run_op("R5", a, b, acc, 2'(v), 1'b1, 1'b0, 8'hFF, 1'b0, 0);
        end
    endtask

    task automatic t_mask;
        logic [511:0] a, b, acc;
        for (int i = 0; i < 8; i++) begin
            a[i*64 +: 64]   = 64'h0001_0203_0405_0607 << i;
            b[i*64 +: 64]   = 64'h000C_0000_0000_0011;
            acc[i*64 +: 64] = 64'hCAFE_0000_0000_0000 + 64'(i);
        end
        run_op("R6", a, b, acc, 2'd2, 1'b0, 1'b1, 8'b1010_0110, 1'b0, 0);
        run_op("R6", a, b, acc, 2'd1, 1'b1, 1'b1, 8'b0000_0001, 1'b0, 0);
        run_op("R7", a, b, acc, 2'd2, 1'b1, 1'b1, 8'b0101_1001, 1'b1, 0);
    endtask

    task automatic t_capture;
        logic [511:0] a, b, acc;
        for (int i = 0; i < 8; i++) begin
            a[i*64 +: 64]   = 64'h000B_EEF0_1234_0000 + 64'(i * 12345);
            b[i*64 +: 64]   = 64'h0006_1111_2222_3333 ^ 64'(i << 20);
            acc[i*64 +: 64] = 64'h0F0F_0F0F_0F0F_0F0F;
        end
        // R9 inputs flipped after capture; R10 start while busy ignored
        run_op("R9", a, b, acc, 2'd1, 1'b1, 1'b1, 8'b0000_1011, 1'b0, 1);
        run_op("R10", a, b, acc, 2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; src_a = '0; src_b = '0; acc_in = '0;
        vlen_sel = '0; hi_sel = 1'b0; mask_en = 1'b0; lane_mask = '0; zero_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_low_mode();
        t_high_corner();
        t_upper_bits();
        t_wrap();
        t_vlen();
        t_mask();
        t_capture();
        finished = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule